// File: doc/BRIEF.md
# Read-Capture Delay Search Engine

This block searches for a working read-capture delay on a serial flash controller that keeps one timing register per chip select. The capture setting is an 8-bit field. It combines a coarse delay counted in whole core-clock cycles, an enable for a fine input delay, and a 4-bit fine delay step. After a start pulse, the engine writes candidate settings one at a time to the timing register of the selected device. After each write it asks an external checker to run a read trial and report pass or fail. It stops at the first setting that passes.

For each coarse value, the engine first tries the setting with the fine delay disabled. Only after that trial fails does it enable the fine delay and sweep all sixteen steps. Each divider ratio has its own byte lane in the timing word. The engine rewrites only the lane for the requested divider and keeps the other lanes as they were when the search started. A one-cycle done pulse reports success or failure, the final setting, and the number of trials used.

Top module: `dlsrch_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, wr_en, trial_req and done are low and trial_cnt is 0.
- R2: Setting field layout: bits 2:0 hold the coarse delay, bit 3 enables the fine delay, and bits 7:4 hold the fine step. For each coarse value, the first setting written has bit 3 clear and bits 7:4 zero.
- R3: After a failed trial with bit 3 clear, the engine writes the same coarse value with bit 3 set and fine steps 0 through 15 in order. After step 15 fails it moves to the next coarse value. Coarse values run from 0 to 5 in order.
- R4: Each write is a one-cycle wr_en pulse. From the next cycle, trial_req stays high until trial_done is seen. Exactly one write precedes every trial.
- R5: The setting occupies bits (div_idx-2)*8+7 down to (div_idx-2)*8 of wr_data. Every other bit equals tim_word_in as sampled on the accepted start.
- R6: wr_addr equals the BASE_ADDR parameter plus four times the chip select sampled on the accepted start.
- R7: A trial answered with trial_pass high ends the search. In the following cycle, done pulses for one cycle with done_ok high and done_field equal to the passing setting.
- R8: If all 102 settings fail, done pulses with done_ok low, done_field 8'hFD and trial_cnt 102.
- R9: trial_cnt is cleared on an accepted start, counts the answered trials, and holds its value after done.
- R10: A start pulse while a search is in progress is ignored. The running search keeps its chip select, divider and base word.
- R11: A start with div_idx outside 2..5 produces done in the next cycle with done_ok low, no write and trial_cnt 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| div_idx | input | 3 | Clock divider index, valid 2..5 |
| cs | input | 2 | Chip select of the device under search |
| tim_word_in | input | 32 | Current timing-register contents, sampled at start |
| wr_en | output | 1 | Timing-register write strobe |
| wr_addr | output | 12 | Timing-register address |
| wr_data | output | 32 | Timing-register write data |
| trial_req | output | 1 | Request for a read trial, held until answered |
| trial_done | input | 1 | Trial result valid |
| trial_pass | input | 1 | Trial result, high for pass |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | High when a passing setting was found |
| done_field | output | 8 | Final 8-bit setting |
| trial_cnt | output | 7 | Trials answered since the last accepted start |

## Verification
Two events can fall in the same cycle during a search: a new start pulse and the trial answer that advances the search. The bench raises start, with a different chip select and divider, in cycles where a trial response is arriving. The search must not restart or retarget. Every later write is compared against the address, lane and base word of the first start, and the final result and trial count must match a search that was never disturbed.

// File: rtl/dlsrch_pkg.sv
package dlsrch_pkg;

    localparam int FIELD_W    = 8;
    localparam int COARSE_W   = 3;
    localparam int FINE_W     = 4;
    localparam int COARSE_MAX = 5;
    localparam int FINE_STEPS = 1 << FINE_W;
    localparam int MAX_TRIALS = (COARSE_MAX + 1) * (FINE_STEPS + 1);

    // bit order follows the register field: fine[7:4], enable[3], coarse[2:0]
    typedef struct packed {
        logic [FINE_W-1:0]   fine;
        logic                en;
        logic [COARSE_W-1:0] coarse;
    } dly_field_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_TRIAL = 2'd2,
        ST_FIN   = 2'd3
    } srch_st_e;

    function automatic dly_field_t first_of(input logic [COARSE_W-1:0] c);
        dly_field_t f;
        f.fine   = '0;
        f.en     = 1'b0;
        f.coarse = c;
        return f;
    endfunction

endpackage

// File: rtl/dlsrch_step.sv
module dlsrch_step
    import dlsrch_pkg::*;
(
    input  dly_field_t cur,
    output dly_field_t nxt,
    output logic       last
);
    localparam logic [FINE_W-1:0]   FINE_TOP = FINE_W'(FINE_STEPS - 1);
    localparam logic [COARSE_W-1:0] CRS_TOP  = COARSE_W'(COARSE_MAX);

    always_comb begin
        nxt  = cur;
        last = 1'b0;
        if (!cur.en) begin
            nxt.en   = 1'b1;
            nxt.fine = '0;
        end else if (cur.fine != FINE_TOP) begin
            nxt.fine = cur.fine + 1'b1;
        end else if (cur.coarse != CRS_TOP) begin
            nxt = first_of(cur.coarse + 1'b1);
        end else begin
            last = 1'b1;
        end
    end
endmodule

// File: rtl/dlsrch_merge.sv
module dlsrch_merge
    import dlsrch_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int LANES  = WORD_W / FIELD_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] base_word,
    input  dly_field_t        field,
    input  logic [LANE_W-1:0] lane,
    output logic [WORD_W-1:0] word
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word[l*FIELD_W +: FIELD_W] =
            (lane == LANE_W'(l)) ? field : base_word[l*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/dlsrch_top.sv
module dlsrch_top
    import dlsrch_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 12,
    parameter int CS_W    = 2,
    parameter int DIV_W   = 3,
    parameter int DIV_MIN = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0C0,
    localparam int LANES  = WORD_W / FIELD_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W  = $clog2(MAX_TRIALS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DIV_W-1:0]   div_idx,
    input  logic [CS_W-1:0]    cs,
    input  logic [WORD_W-1:0]  tim_word_in,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [WORD_W-1:0]  wr_data,
    output logic               trial_req,
    input  logic               trial_done,
    input  logic               trial_pass,
    output logic               done,
    output logic               done_ok,
    output logic [FIELD_W-1:0] done_field,
    output logic [CNT_W-1:0]   trial_cnt
);
    localparam logic [DIV_W-1:0] DIV_LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] DIV_HI = DIV_W'(DIV_MIN + LANES - 1);

    srch_st_e            st_q;
    logic [CS_W-1:0]     cs_q;
    logic [LANE_W-1:0]   lane_q;
    logic [WORD_W-1:0]   word_q;
    dly_field_t          fld_q;
    dly_field_t          fld_nxt;
    logic                fld_last;
    logic [CNT_W-1:0]    cnt_q;
    logic                ok_q;
    logic                div_ok;

    assign div_ok = (div_idx >= DIV_LO) && (div_idx <= DIV_HI);

    dlsrch_step u_step (
        .cur  (fld_q),
        .nxt  (fld_nxt),
        .last (fld_last)
    );

    dlsrch_merge #(.WORD_W(WORD_W)) u_merge (
        .base_word (word_q),
        .field     (fld_q),
        .lane      (lane_q),
        .word      (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cs_q   <= '0;
            lane_q <= '0;
            word_q <= '0;
            fld_q  <= '0;
            cnt_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    cs_q   <= cs;
                    word_q <= tim_word_in;
                    fld_q  <= first_of('0);
                    cnt_q  <= '0;
                    ok_q   <= 1'b0;
                    if (div_ok) begin
                        lane_q <= LANE_W'(div_idx - DIV_LO);
                        st_q   <= ST_WRITE;
                    end else begin
                        st_q   <= ST_FIN;
                    end
                end
                ST_WRITE: st_q <= ST_TRIAL;
                ST_TRIAL: if (trial_done) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (trial_pass) begin
                        ok_q <= 1'b1;
                        st_q <= ST_FIN;
                    end else if (fld_last) begin
                        st_q <= ST_FIN;
                    end else begin
                        fld_q <= fld_nxt;
                        st_q  <= ST_WRITE;
                    end
                end
                ST_FIN: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_en      = (st_q == ST_WRITE);
    assign trial_req  = (st_q == ST_TRIAL);
    assign done       = (st_q == ST_FIN);
    assign wr_addr    = BASE_ADDR + ADDR_W'({cs_q, 2'b00});
    assign done_ok    = ok_q;
    assign done_field = fld_q;
    assign trial_cnt  = cnt_q;
endmodule

// File: rtl/dlsrch_chk.sv
module dlsrch_chk
    import dlsrch_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             trial_req,
    input logic             trial_done,
    input logic             trial_pass,
    input logic             done,
    input logic             done_ok,
    input logic [CNT_W-1:0] trial_cnt
);
    // R4
    wr_then_trial_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> trial_req);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trial_req && !trial_done) |=> trial_req);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    ok_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_ok) |-> $past(trial_done && trial_pass));

    // R9
    trial_cap_chk: assert property (@(posedge clk) disable iff (rst)
        trial_cnt <= CNT_W'(MAX_TRIALS));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trial_req && !wr_en && !done && $past(!rst)) |-> $stable(trial_cnt) || $past(!trial_req));
endmodule

bind dlsrch_top dlsrch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .trial_req  (trial_req),
    .trial_done (trial_done),
    .trial_pass (trial_pass),
    .done       (done),
    .done_ok    (done_ok),
    .trial_cnt  (trial_cnt)
);

// File: tb/dlsrch_top_tb.sv
module dlsrch_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  div_idx = 3'd2;
    logic [1:0]  cs = 2'd0;
    logic [31:0] tim_word_in = '0;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        trial_req;
    logic        trial_done = 1'b0;
    logic        trial_pass = 1'b0;
    logic        done;
    logic        done_ok;
    logic [7:0]  done_field;
    logic [6:0]  trial_cnt;

    always #4 clk = ~clk;

    dlsrch_top u_dut (
        .clk(clk), .rst(rst), .start(start), .div_idx(div_idx), .cs(cs),
        .tim_word_in(tim_word_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trial_req(trial_req), .trial_done(trial_done),
        .trial_pass(trial_pass), .done(done), .done_ok(done_ok),
        .done_field(done_field), .trial_cnt(trial_cnt)
    );

    int checks = 0;
    int fails  = 0;
    int wchecks = 0;
    int wfails  = 0;

    // search context expected by the write monitor
    logic [1:0]  exp_cs   = '0;
    logic [2:0]  exp_div  = 3'd2;
    logic [31:0] exp_word = '0;
    logic [7:0]  target   = 8'h00;
    int          wk       = 0;
    logic [7:0]  cur_fld  = '0;
    int          lat_cnt  = 0;

    function automatic logic [7:0] exp_fld(int k);
        int c  = k / 17;
        int r  = k % 17;
        int rr = r - 1;
        if (r == 0) return {5'b0, c[2:0]};
        return {rr[3:0], 1'b1, c[2:0]};
    endfunction

    function automatic logic [31:0] exp_data(int k);
        logic [31:0] w = exp_word;
        int ln = int'(exp_div) - 2;
        w[ln*8 +: 8] = exp_fld(k);
        return w;
    endfunction

    // write monitor and trial responder
    always @(posedge clk) begin
        if (rst) begin
            wk <= 0; trial_done <= 1'b0; trial_pass <= 1'b0; lat_cnt <= 0;
        end else begin
            if (done) wk <= 0;
            if (wr_en) begin
                wchecks <= wchecks + 2;
                if (wr_data !== exp_data(wk)) begin
                    wfails <= wfails + 1;
                    $display("FAIL R2/R3/R5 write %0d data %h expected %h", wk, wr_data, exp_data(wk));
                end
                if (wr_addr !== 12'h0C0 + {8'd0, exp_cs, 2'b00}) begin
                    wfails <= wfails + 1;
                    $display("FAIL R6 write %0d addr %h expected %h", wk, wr_addr, 12'h0C0 + {8'd0, exp_cs, 2'b00});
                end
                cur_fld <= wr_data[(int'(exp_div)-2)*8 +: 8];
                wk <= wk + 1;
            end
            if (trial_done) begin
                trial_done <= 1'b0;
                lat_cnt    <= 0;
            end else if (trial_req) begin
                if (lat_cnt == 2) begin
                    trial_done <= 1'b1;
                    trial_pass <= (cur_fld == target);
                    lat_cnt    <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [1:0] c, input logic [2:0] d, input logic [31:0] w);
        @(negedge clk);
        cs = c; div_idx = d; tim_word_in = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // one scenario: start, optional disturbing start, then judge the result
    task automatic run_search(input string tag, input logic [1:0] c, input logic [2:0] d,
                              input logic [31:0] w, input logic [7:0] tgt, input bit exp_ok,
                              input logic [7:0] exp_f, input int exp_n, input bit disturb);
        bit seen;
        exp_cs = c; exp_div = d; exp_word = w; target = tgt;
        pulse_start(c, d, w);
        if (disturb) begin
            for (int j = 0; j < 40; j++) begin
                @(negedge clk);
                if (j % 5 == 3) begin
                    cs = ~c; div_idx = (d == 3'd2) ? 3'd5 : 3'd2; tim_word_in = ~w; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
            end
            start = 1'b0;
        end
        wait_done(seen);
        check(seen, {tag, " done seen"}, int'(seen), 1);
        check(done_ok == exp_ok, {tag, " R7/R8 done_ok"}, int'(done_ok), int'(exp_ok));
        check(done_field == exp_f, {tag, " R7/R8 done_field"}, int'(done_field), int'(exp_f));
        check(int'(trial_cnt) == exp_n, {tag, " R9 trial_cnt"}, int'(trial_cnt), exp_n);
        check(wk == exp_n, {tag, " R4 writes equal trials"}, wk, exp_n);
        @(negedge clk);
        check(!done, {tag, " R7 done one cycle"}, int'(done), 0);
        check(int'(trial_cnt) == exp_n, {tag, " R9 count held"}, int'(trial_cnt), exp_n);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!wr_en && !trial_req && !done, "R1 idle in reset", int'({wr_en, trial_req, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!wr_en && !trial_req && !done, "R1 idle after reset", int'({wr_en, trial_req, done}), 0);
        check(trial_cnt == 7'd0, "R1 count zero", int'(trial_cnt), 0);
    endtask

    task automatic t_bad_div(input logic [2:0] d);
        bit seen;
        exp_cs = 2'd1; exp_div = 3'd2; exp_word = '0; target = 8'h00;
        pulse_start(2'd1, d, 32'h1234_5678);
        seen = done;
        check(seen, "R11 done right after start", int'(seen), 1);
        check(!done_ok, "R11 failure reported", int'(done_ok), 0);
        check(trial_cnt == 7'd0 && wk == 0, "R11 no write or trial", wk, 0);
        @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 60000);
            $display("== %0d vectors applied, %0d miscompares ==", checks + wchecks + 1, fails + wfails + 1);
            $finish;
        end
    end

    initial begin
        t_reset();
        // R2 first setting passes
        run_search("R2 first", 2'd0, 3'd2, 32'hA5A5_A5A5, 8'h00, 1'b1, 8'h00, 1, 1'b0);
        // R3 pass inside the fine sweep of coarse 2
        run_search("R3 fine", 2'd3, 3'd3, 32'hDEAD_BEEF, 8'h5A, 1'b1, 8'h5A, 41, 1'b0);
        // R2 pass on the no-delay setting of coarse 4, top lane (R5)
        run_search("R5 lane3", 2'd2, 3'd5, 32'h0F1E_2D3C, 8'h04, 1'b1, 8'h04, 69, 1'b0);
        // R8 exhaustive failure
        run_search("R8 allfail", 2'd1, 3'd4, 32'h7766_5544, 8'hFF, 1'b0, 8'hFD, 102, 1'b0);
        // R10 start pulses during a search are ignored
        run_search("R10 busy", 2'd1, 3'd3, 32'hCAFE_0001, 8'h3B, 1'b1, 8'h3B, 56, 1'b1);
        // R11 out-of-range dividers
        t_bad_div(3'd1);
        t_bad_div(3'd6);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks + wchecks, fails + wfails);
        $finish;
    end
endmodule